// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block is the address and command register of a registered memory module. On each rising clock edge it captures 22 gated command bits, two clock-enable bits and two termination-control bits. Each registered bit leaves the block on two identical output copies, so one input feeds two loads.

The 22 command bits load only when at least one of the two active-low chip selects is asserted. When neither chip select is asserted and the gating enable is high, those bits keep their previous value. This saves output toggling while the module is idle. When the gating enable is low, the command bits load on every edge. The clock-enable and termination bits are not gated and load on every edge.

The block also checks parity on the command bits. The parity bit arrives one clock after the data it covers. A mismatch drives an active-low error flag, which then stays low for a fixed number of cycles.

Top module: `cmdreg_top`

## Requirements
- R1: While `rst` is high at a rising edge, every registered output becomes zero after that edge and `err_n` becomes 1.
- R2: At a rising edge where `cs_n[0]` or `cs_n[1]` is 0, the command outputs take the value of `cmd_in`.
- R3: At a rising edge where `cs_n` is 2'b11 and `gate_en` is 1, the command outputs keep their previous value.
- R4: At a rising edge where `gate_en` is 0, the command outputs take `cmd_in` whatever the value of `cs_n`.
- R5: At every rising edge, `cke_qa` and `cke_qb` take `cke_in`, and `odt_qa` and `odt_qb` take `odt_in`, whatever the values of `cs_n` and `gate_en`.
- R6: The A and B copies of each output group always carry the same value.
- R7: Parity is even. `par_in` sampled at edge k+1 covers the `cmd_in` value sampled at edge k. An error exists when the XOR of those 22 bits and `par_in` equals 1.
- R8: The parity check runs only when a chip select was asserted at edge k. `gate_en` has no effect on the check.
- R9: When an error is detected at an edge, `err_n` is 0 for the two cycles after that edge and then returns to 1, unless a new error occurs.
- R10: An error detected while `err_n` is already 0 restarts the two-cycle hold from that edge.
- R11: Reset asserted while `err_n` is 0 returns `err_n` to 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 2 | Chip selects, active low |
| gate_en | input | 1 | When 1, command bits load only when a chip select is asserted |
| cmd_in | input | 22 | Gated command and address bits |
| cke_in | input | 2 | Clock-enable bits, never gated |
| odt_in | input | 2 | Termination-control bits, never gated |
| par_in | input | 1 | Even parity for the command sampled one edge earlier |
| cmd_qa | output | 22 | Registered command, copy A |
| cmd_qb | output | 22 | Registered command, copy B |
| cke_qa | output | 2 | Registered clock enable, copy A |
| cke_qb | output | 2 | Registered clock enable, copy B |
| odt_qa | output | 2 | Registered termination control, copy A |
| odt_qb | output | 2 | Registered termination control, copy B |
| err_n | output | 1 | Parity error flag, active low, held two cycles |

## Verification
A wrong gating decision appears on the command outputs one edge after the bad capture, and the wrong value stays there until a chip select reloads the register. A wrong delayed-data copy or a wrong check-valid bit shows on `err_n` one edge after the parity bit is sampled: the flag either falls on good parity or stays high on bad parity. A wrong hold counter shows as `err_n` rising one cycle early or late, or failing to extend on a back-to-back error. In that case the edge where the flag should be high or low gives a wrong value within three cycles.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    parameter int CMD_W      = 22;
    parameter int CTRL_W     = 2;
    parameter int HOLD_CYC   = 2;
    localparam int HOLD_W    = $clog2(HOLD_CYC + 1);

    typedef logic [CMD_W-1:0]  cmd_t;
    typedef logic [CTRL_W-1:0] ctrl_t;
    typedef logic [HOLD_W-1:0] hold_t;

    typedef struct packed {
        ctrl_t cke;
        ctrl_t odt;
    } side_t;

    function automatic logic any_select(input logic [1:0] csn);
        return (csn != 2'b11);
    endfunction

    function automatic logic odd_mismatch(input cmd_t data, input logic par);
        return (^data) ^ par;
    endfunction
endpackage

// File: rtl/cmdreg_gated.sv
module cmdreg_gated
    import cmdreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  logic  gate_en,
    input  cmd_t  cmd_d,
    input  side_t side_d,
    output cmd_t  cmd_q,
    output side_t side_q
);
    logic load_cmd;
    assign load_cmd = sel || !gate_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load_cmd) begin
            cmd_q <= cmd_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            side_q <= '0;
        end else begin
            side_q <= side_d;
        end
    end

    // R3
    a_r3_hold_when_gated: assert property (@(posedge clk) disable iff (rst)
        (!sel && gate_en) |=> $stable(cmd_q));
    // R5
    a_r5_side_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (side_q == $past(side_d)));
    // R2 R4
    a_r2_cmd_loads: assert property (@(posedge clk) disable iff (rst)
        (sel || !gate_en) |=> (cmd_q == $past(cmd_d)));
endmodule

// File: rtl/cmdreg_parity.sv
module cmdreg_parity
    import cmdreg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  cmd_t cmd_d,
    input  logic par,
    output logic err_n
);
    cmd_t  cmd_dly;
    logic  chk_vld;
    hold_t hold_cnt;
    logic  err_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_dly <= '0;
            chk_vld <= 1'b0;
        end else begin
            cmd_dly <= cmd_d;
            chk_vld <= sel;
        end
    end

    assign err_now = chk_vld && odd_mismatch(cmd_dly, par);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (err_now) begin
            hold_cnt <= hold_t'(HOLD_CYC);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign err_n = (hold_cnt == '0);

    // R9
    a_r9_min_hold: assert property (@(posedge clk) disable iff (rst)
        $fell(err_n) |=> !err_n);
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= hold_t'(HOLD_CYC));
    // R8
    a_r8_idle_no_error: assert property (@(posedge clk) disable iff (rst)
        (!chk_vld && err_n) |=> err_n);
    // R10
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        err_now |=> (hold_cnt == hold_t'(HOLD_CYC)));
endmodule

// File: rtl/cmdreg_top.sv
module cmdreg_top
    import cmdreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cs_n,
    input  logic        gate_en,
    input  logic [21:0] cmd_in,
    input  logic [1:0]  cke_in,
    input  logic [1:0]  odt_in,
    input  logic        par_in,
    output logic [21:0] cmd_qa,
    output logic [21:0] cmd_qb,
    output logic [1:0]  cke_qa,
    output logic [1:0]  cke_qb,
    output logic [1:0]  odt_qa,
    output logic [1:0]  odt_qb,
    output logic        err_n
);
    localparam int COPIES = 2;

    logic  sel;
    cmd_t  cmd_r;
    side_t side_r;
    side_t side_in;
    cmd_t  cmd_copy  [COPIES];
    side_t side_copy [COPIES];

    assign sel          = any_select(cs_n);
    assign side_in.cke  = cke_in;
    assign side_in.odt  = odt_in;

    cmdreg_gated u_reg (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .gate_en (gate_en),
        .cmd_d   (cmd_in),
        .side_d  (side_in),
        .cmd_q   (cmd_r),
        .side_q  (side_r)
    );

    cmdreg_parity u_par (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .cmd_d (cmd_in),
        .par   (par_in),
        .err_n (err_n)
    );

    for (genvar c = 0; c < COPIES; c++) begin : g_fanout
        assign cmd_copy[c]  = cmd_r;
        assign side_copy[c] = side_r;
    end

    assign cmd_qa = cmd_copy[0];
    assign cmd_qb = cmd_copy[1];
    assign cke_qa = side_copy[0].cke;
    assign cke_qb = side_copy[1].cke;
    assign odt_qa = side_copy[0].odt;
    assign odt_qb = side_copy[1].odt;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (err_n && cmd_qa == '0 && cke_qa == '0 && odt_qa == '0));
endmodule

// File: tb/cmdreg_top_test.sv
module cmdreg_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  cs_n;
    logic        gate_en;
    logic [21:0] cmd_in;
    logic [1:0]  cke_in;
    logic [1:0]  odt_in;
    logic        par_in;
    logic [21:0] cmd_qa, cmd_qb;
    logic [1:0]  cke_qa, cke_qb, odt_qa, odt_qb;
    logic        err_n;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cmdreg_top uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .gate_en(gate_en),
        .cmd_in(cmd_in), .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
        .cmd_qa(cmd_qa), .cmd_qb(cmd_qb), .cke_qa(cke_qa), .cke_qb(cke_qb),
        .odt_qa(odt_qa), .odt_qb(odt_qb), .err_n(err_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] cs, input logic ge,
                        input logic [21:0] d, input logic [1:0] ck,
                        input logic [1:0] od, input logic p);
        @(negedge clk);
        rst = r; cs_n = cs; gate_en = ge; cmd_in = d;
        cke_in = ck; odt_in = od; par_in = p;
        @(posedge clk);
        #1;
    endtask

    function automatic logic even_par(input logic [21:0] d);
        return ^d;
    endfunction

    task automatic t_reset();
        step(1'b1, 2'b00, 1'b1, 22'h3FFFFF, 2'b11, 2'b11, 1'b1);
        check("R1 cmd", {10'd0, cmd_qa}, 32'd0);
        check("R1 cke/odt", {28'd0, cke_qa, odt_qa}, 32'd0);
        check("R1 err_n", {31'd0, err_n}, 32'd1);
    endtask

    task automatic t_capture();
        step(1'b0, 2'b10, 1'b1, 22'h2A5A5A, 2'b01, 2'b10, 1'b0);
        check("R2 cs0", {10'd0, cmd_qa}, {10'd0, 22'h2A5A5A});
        step(1'b0, 2'b01, 1'b1, 22'h15A5A5, 2'b10, 2'b01, even_par(22'h2A5A5A));
        check("R2 cs1", {10'd0, cmd_qa}, {10'd0, 22'h15A5A5});
        check("R6 cmd copy", {10'd0, cmd_qb}, {10'd0, cmd_qa});
        check("R6 side copy", {28'd0, cke_qb, odt_qb}, {28'd0, cke_qa, odt_qa});
        check("R7 good parity", {31'd0, err_n}, 32'd1);
    endtask

    task automatic t_gating();
        step(1'b0, 2'b11, 1'b1, 22'h000F0F, 2'b11, 2'b00, even_par(22'h15A5A5));
        check("R3 hold", {10'd0, cmd_qa}, {10'd0, 22'h15A5A5});
        check("R5 cke gated", {30'd0, cke_qa}, 32'd3);
        check("R5 odt gated", {30'd0, odt_qb}, 32'd0);
        step(1'b0, 2'b11, 1'b0, 22'h0C0C0C, 2'b00, 2'b11, 1'b0);
        check("R4 ungated load", {10'd0, cmd_qb}, {10'd0, 22'h0C0C0C});
        check("R5 cke", {30'd0, cke_qb}, 32'd0);
    endtask

    task automatic t_parity_error();
        step(1'b0, 2'b10, 1'b0, 22'h000007, 2'b00, 2'b00, 1'b0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, ~even_par(22'h000007));
        check("R7 error low", {31'd0, err_n}, 32'd0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R9 second cycle", {31'd0, err_n}, 32'd0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R9 released", {31'd0, err_n}, 32'd1);
    endtask

    task automatic t_idle_ignored();
        step(1'b0, 2'b11, 1'b0, 22'h000001, 2'b00, 2'b00, 1'b0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R8 no check when idle", {31'd0, err_n}, 32'd1);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R8 still idle", {31'd0, err_n}, 32'd1);
    endtask

    task automatic t_restart();
        step(1'b0, 2'b01, 1'b1, 22'h000003, 2'b00, 2'b00, 1'b0);
        step(1'b0, 2'b01, 1'b1, 22'h000001, 2'b00, 2'b00, 1'b1);
        check("R7 first error", {31'd0, err_n}, 32'd0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R10 second error", {31'd0, err_n}, 32'd0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R10 extended", {31'd0, err_n}, 32'd0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R10 released", {31'd0, err_n}, 32'd1);
    endtask

    task automatic t_reset_in_hold();
        step(1'b0, 2'b00, 1'b1, 22'h100000, 2'b00, 2'b00, 1'b0);
        step(1'b0, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R7 error", {31'd0, err_n}, 32'd0);
        step(1'b1, 2'b11, 1'b1, 22'h000000, 2'b00, 2'b00, 1'b0);
        check("R11 reset clears err", {31'd0, err_n}, 32'd1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_capture();
                t_gating();
                t_parity_error();
                t_idle_ignored();
                t_restart();
                t_reset_in_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule